// File: doc/BRIEF.md
# External Interrupt Controller with Per-Line Trigger Select

This block gathers 32 asynchronous interrupt request pins and turns them into processor interrupts. Each pin is first brought into the clock domain through a short flop chain. It then goes to a detector whose trigger type is chosen per line: low level, high level, falling edge, rising edge, or any edge. A detected event sets a sticky pending flag. Software clears a pending flag by writing a one to it. A per-line mask bit decides whether a pending flag may reach an interrupt output.

The lines form four banks of eight. Each bank has three registers on a plain register bus: a trigger configuration word, a mask byte and a pending byte. Lines 0 to 15 each drive a dedicated interrupt output. Lines 16 to 31 share one combined output, and software reads the pending bytes to find which line is active. The bus carries no streaming data and has no back-pressure. A write is taken on the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational from the address while `bus_en` is high and `bus_we` is low, and `bus_rdata` is zero otherwise.

Top module: `eint_ctrl`

## Requirements
- R1: While reset is asserted and directly after it: every trigger field reads 0, every mask byte reads 0xFF, every pending byte reads 0x00, and all interrupt outputs are low.
- R2: In a bank's configuration word, line k of the bank (k = 0..7) has a 3-bit trigger field at bits [4k+2:4k]. Bit 4k+3 is reserved: it is not stored and always reads 0.
- R3: Trigger code 000 means level low and 001 means level high. While the level is active, the pending flag is set again on every clock. A clear made while the level is active therefore has no lasting effect, and a clear made after the level goes inactive does take effect.
- R4: Trigger code 010 sets pending only on a falling edge of the synchronised input. Code 011 sets pending only on a rising edge.
- R5: Any trigger code with bit 2 set (1xx) sets pending on both rising and falling edges.
- R6: Writing to a pending byte clears each bit written as 1 and leaves each bit written as 0 unchanged. If a detection and a clear hit the same line in the same cycle, the detection wins.
- R7: Reading a pending byte returns the latched flags in bits [7:0] whatever the mask holds. Bits [31:8] of pending and mask reads are 0.
- R8: A mask bit of 1 blocks its line. For each line n in 0..15, `irq_line[n]` is high exactly when that line is pending and its mask bit is 0.
- R9: `irq_shared` is high exactly when at least one of lines 16..31 is pending with its mask bit at 0.
- R10: A level change on an input that then stays stable shows in its pending flag after the third rising clock edge that follows the change, and not before.
- R11: `bus_addr[1:0]` selects the bank (line = 8*bank + k). `bus_addr[3:2]` selects the register: 0 configuration, 1 mask, 2 pending, 3 unmapped. Unmapped reads return 0, writes to the unmapped register change nothing, and an access to one bank leaves the other banks alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 32 | Asynchronous interrupt request pins, one per line |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | {register select[1:0], bank[1:0]} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| irq_line | output | 16 | Dedicated interrupt outputs for lines 0..15 |
| irq_shared | output | 1 | Combined interrupt output for lines 16..31 |

## Verification
The bench runs every line through all eight trigger codes. For each, it drives the active transition, then the opposite one, then a clear while the input is active, and checks that the right lines stay quiet. A detector with swapped edge polarity would set pending on the opposite transition or miss the active one. A design that let a clear win over detection would show a level line as cleared while its input is still active. A mask applied to the pending flag itself would hide latched events from the pending read, and a wrong split between dedicated and shared lines would show up on the wrong output. The bench also samples one cycle early, so an extra or a missing synchroniser stage makes the flag appear a cycle early or late.

// File: rtl/eint_pkg.sv
package eint_pkg;

  localparam int TRIG_W  = 3;
  localparam int FIELD_W = 4;

  typedef logic [TRIG_W-1:0] trig_t;

  // base trigger modes selected by the two low field bits when bit 2 is clear
  typedef enum logic [1:0] {
    MODE_LVL_LO = 2'd0,
    MODE_LVL_HI = 2'd1,
    MODE_FALL   = 2'd2,
    MODE_RISE   = 2'd3
  } base_mode_e;

  typedef enum logic [1:0] {
    KIND_CFG  = 2'd0,
    KIND_MASK = 2'd1,
    KIND_PEND = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;

  function automatic logic trig_fire(trig_t t, logic cur, logic prev);
    logic fire;
    if (t[2]) begin
      fire = cur ^ prev;
    end else begin
      case (base_mode_e'(t[1:0]))
        MODE_LVL_LO: fire = ~cur;
        MODE_LVL_HI: fire = cur;
        MODE_FALL:   fire = prev & ~cur;
        default:     fire = ~prev & cur;
      endcase
    end
    return fire;
  endfunction

endpackage

// File: rtl/eint_sync_detect.sv
module eint_sync_detect
  import eint_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin_async,
  input  trig_t trig,
  output logic  hit
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;
  logic                   cur;

  assign cur = chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= (chain_q << 1) | SYNC_STAGES'(pin_async);
      prev_q  <= cur;
    end
  end

  assign hit = trig_fire(trig, cur, prev_q);

endmodule

// File: rtl/eint_bank.sv
module eint_bank
  import eint_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic                    mask_we,
  input  logic                    pend_we,
  input  trig_t [LINES-1:0]       cfg_wval,
  input  logic  [LINES-1:0]       bit_wval,
  input  logic  [LINES-1:0]       hit,
  output trig_t [LINES-1:0]       cfg_q,
  output logic  [LINES-1:0]       mask_q,
  output logic  [LINES-1:0]       pend_q,
  output logic  [LINES-1:0]       clr_req
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign clr_req[i] = pend_we & bit_wval[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i]  <= '0;
        mask_q[i] <= 1'b1;
        pend_q[i] <= 1'b0;
      end else begin
        if (cfg_we)  cfg_q[i]  <= cfg_wval[i];
        if (mask_we) mask_q[i] <= bit_wval[i];
        // detection overrides a simultaneous clear
        pend_q[i] <= (pend_q[i] & ~clr_req[i]) | hit[i];
      end
    end
  end

endmodule

// File: rtl/eint_irq_merge.sv
module eint_irq_merge #(
  parameter int NUM_LINES       = 32,
  parameter int DEDICATED_LINES = 16
) (
  input  logic [NUM_LINES-1:0]       pend,
  input  logic [NUM_LINES-1:0]       mask,
  output logic [DEDICATED_LINES-1:0] irq_line,
  output logic                       irq_shared
);

  logic [NUM_LINES-1:0] live;
  assign live     = pend & ~mask;
  assign irq_line = live[DEDICATED_LINES-1:0];

  if (DEDICATED_LINES < NUM_LINES) begin : g_shared
    assign irq_shared = |live[NUM_LINES-1:DEDICATED_LINES];
  end else begin : g_no_shared
    assign irq_shared = 1'b0;
  end

endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
  import eint_pkg::*;
#(
  parameter int  NUM_BANKS       = 4,
  parameter int  BANK_LINES      = 8,
  parameter int  DEDICATED_LINES = 16,
  parameter int  SYNC_STAGES     = 2,
  parameter int  DATA_W          = 32,
  localparam int NUM_LINES       = NUM_BANKS * BANK_LINES,
  localparam int BANK_W          = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W          = BANK_W + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LINES-1:0]       ext_pin,
  input  logic                       bus_en,
  input  logic                       bus_we,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [DEDICATED_LINES-1:0] irq_line,
  output logic                       irq_shared
);

  trig_t [NUM_BANKS-1:0][BANK_LINES-1:0] cfg_all;
  logic  [NUM_BANKS-1:0][BANK_LINES-1:0] mask_all;
  logic  [NUM_BANKS-1:0][BANK_LINES-1:0] pend_all;
  logic  [NUM_BANKS-1:0][BANK_LINES-1:0] clr_all;
  logic  [NUM_LINES-1:0]                 hit_vec;
  logic  [NUM_LINES-1:0]                 pend_vec;
  logic  [NUM_LINES-1:0]                 mask_vec;
  logic  [NUM_LINES-1:0]                 clr_vec;

  assign pend_vec = pend_all;
  assign mask_vec = mask_all;
  assign clr_vec  = clr_all;

  // ---------------- access decode ----------------
  logic [BANK_W-1:0] sel_bank;
  reg_kind_e         sel_kind;
  logic              wr_go;
  logic              rd_go;
  logic              rd_is_cfg;

  assign sel_bank  = bus_addr[BANK_W-1:0];
  assign sel_kind  = reg_kind_e'(bus_addr[ADDR_W-1:BANK_W]);
  assign wr_go     = bus_en & bus_we;
  assign rd_go     = bus_en & ~bus_we;
  assign rd_is_cfg = rd_go & (sel_kind == KIND_CFG);

  // write value slices shared by all banks
  trig_t [BANK_LINES-1:0] cfg_wval;
  logic  [BANK_LINES-1:0] bit_wval;
  logic                   wdata_unused;

  for (genvar i = 0; i < BANK_LINES; i++) begin : g_wslice
    assign cfg_wval[i] = bus_wdata[i*FIELD_W +: TRIG_W];
  end
  assign bit_wval     = bus_wdata[BANK_LINES-1:0];
  assign wdata_unused = ^bus_wdata;

  // ---------------- banks ----------------
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic here;
    assign here = wr_go & (sel_bank == BANK_W'(b));

    eint_bank #(
      .LINES (BANK_LINES)
    ) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (here & (sel_kind == KIND_CFG)),
      .mask_we  (here & (sel_kind == KIND_MASK)),
      .pend_we  (here & (sel_kind == KIND_PEND)),
      .cfg_wval (cfg_wval),
      .bit_wval (bit_wval),
      .hit      (hit_vec[b*BANK_LINES +: BANK_LINES]),
      .cfg_q    (cfg_all[b]),
      .mask_q   (mask_all[b]),
      .pend_q   (pend_all[b]),
      .clr_req  (clr_all[b])
    );
  end

  // ---------------- per-line synchroniser and detector ----------------
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    eint_sync_detect #(
      .SYNC_STAGES (SYNC_STAGES)
    ) det_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (ext_pin[l]),
      .trig      (cfg_all[l / BANK_LINES][l % BANK_LINES]),
      .hit       (hit_vec[l])
    );
  end

  // ---------------- interrupt outputs ----------------
  eint_irq_merge #(
    .NUM_LINES       (NUM_LINES),
    .DEDICATED_LINES (DEDICATED_LINES)
  ) merge_i (
    .pend       (pend_vec),
    .mask       (mask_vec),
    .irq_line   (irq_line),
    .irq_shared (irq_shared)
  );

  // ---------------- read path ----------------
  always_comb begin
    bus_rdata = '0;
    if (rd_go && (int'(sel_bank) < NUM_BANKS)) begin
      case (sel_kind)
        KIND_CFG: begin
          for (int i = 0; i < BANK_LINES; i++) begin
            bus_rdata[i*FIELD_W +: TRIG_W] = cfg_all[sel_bank][i];
          end
        end
        KIND_MASK: bus_rdata[BANK_LINES-1:0] = mask_all[sel_bank];
        KIND_PEND: bus_rdata[BANK_LINES-1:0] = pend_all[sel_bank];
        default:   bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/eint_ctrl_checker.sv
module eint_ctrl_checker #(
  parameter int NUM_LINES       = 32,
  parameter int DEDICATED_LINES = 16,
  parameter int DATA_W          = 32,
  parameter int FIELD_W         = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_read,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic [NUM_LINES-1:0]       hit_vec,
  input logic [NUM_LINES-1:0]       pend_vec,
  input logic [NUM_LINES-1:0]       mask_vec,
  input logic [NUM_LINES-1:0]       clr_vec,
  input logic [DEDICATED_LINES-1:0] irq_line,
  input logic                       irq_shared
);

  function automatic logic [DATA_W-1:0] reserved_bits();
    logic [DATA_W-1:0] r = '0;
    for (int i = 0; i < DATA_W / FIELD_W; i++) r[i*FIELD_W + FIELD_W - 1] = 1'b1;
    return r;
  endfunction

  localparam logic [DATA_W-1:0] RSV = reserved_bits();

  // R1: outputs quiet while reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (irq_line == '0 && !irq_shared));

  // R2: reserved nibble bits never read back as 1
  assert_cfg_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_read |-> ((bus_rdata & RSV) == '0));

  // R3/R4/R5: a pending flag only rises after a detector hit
  assert_pend_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec & ~$past(pend_vec) & ~$past(hit_vec)) == '0));

  // R6: a written one clears the flag unless a detection arrived in that cycle
  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec & $past(clr_vec) & ~$past(hit_vec)) == '0));

  // R8: a dedicated output needs a pending, unmasked line
  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_line & (mask_vec[DEDICATED_LINES-1:0] | ~pend_vec[DEDICATED_LINES-1:0])) == '0));

  // R9: shared output tracks the upper lines
  assert_shared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_shared == (|(pend_vec[NUM_LINES-1:DEDICATED_LINES] & ~mask_vec[NUM_LINES-1:DEDICATED_LINES])));

endmodule

bind eint_ctrl eint_ctrl_checker #(
  .NUM_LINES       (NUM_LINES),
  .DEDICATED_LINES (DEDICATED_LINES),
  .DATA_W          (DATA_W),
  .FIELD_W         (eint_pkg::FIELD_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_read   (rd_is_cfg),
  .bus_rdata  (bus_rdata),
  .hit_vec    (hit_vec),
  .pend_vec   (pend_vec),
  .mask_vec   (mask_vec),
  .clr_vec    (clr_vec),
  .irq_line   (irq_line),
  .irq_shared (irq_shared)
);

// File: tb/eint_ctrl_tb_top.sv
`timescale 1ns/100ps
module eint_ctrl_tb_top;

  localparam int NB  = 4;
  localparam int NL  = 32;
  localparam int DED = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_line;
  logic        irq_shared;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  eint_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_pin    (pins),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_line   (irq_line),
    .irq_shared (irq_shared)
  );

  function automatic logic [3:0] ra(int kind, int bank);
    return 4'((kind << 2) | bank);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_all();
    for (int b = 0; b < NB; b++) wr(ra(2, b), 32'hFF);
  endtask

  task automatic run_case(int line, int code);
    int          b  = line / 8;
    int          s  = line % 8;
    bit          lvl = (code < 2);
    bit          both = (code >= 4);
    logic        idle_v;
    logic [31:0] w, r, one, exp_line;
    string       tag;
    idle_v = (code == 0 || code == 2);
    one    = 32'(1) << s;
    tag    = lvl ? "R3" : (both ? "R5" : "R4");

    pins = '0; pins[line] = idle_v;
    wait_cyc(4);
    w = 32'h3333_3333;
    w[s*4 +: 4] = 4'(code);
    wr(ra(0, b), w);
    rd(ra(0, b), r);
    chk("R2", "trigger field readback", r, w);
    wait_cyc(4);
    wr(ra(2, b), 32'hFF);
    rd(ra(2, b), r);
    chk("R6", "pending cleared while idle", r, 32'h0);

    // active transition and latency (R10)
    @(posedge clk); #1;
    pins[line] = ~idle_v;
    repeat (2) @(posedge clk);
    rd(ra(2, b), r);
    chk("R10", "pending before third edge", r, 32'h0);
    @(posedge clk);
    rd(ra(2, b), r);
    chk(tag, "pending after active transition", r, one);
    for (int ob = 0; ob < NB; ob++) begin
      if (ob != b) begin
        rd(ra(2, ob), r);
        chk("R11", "other bank untouched", r, 32'h0);
      end
    end

    // masked: raw pending visible, outputs quiet
    @(negedge clk);
    chk("R8", "masked dedicated outputs", 32'(irq_line), 32'h0);
    chk("R9", "masked shared output", 32'(irq_shared), 32'h0);
    wr(ra(1, b), 32'hFF & ~one);
    @(negedge clk);
    exp_line = (line < DED) ? (32'(1) << line) : 32'h0;
    chk("R8", "unmasked dedicated outputs", 32'(irq_line), exp_line);
    chk("R9", "unmasked shared output", 32'(irq_shared), 32'(line >= DED));
    wr(ra(1, b), 32'hFF);
    rd(ra(2, b), r);
    chk("R7", "pending raw while masked", r, one);

    // zero write keeps, one write clears (unless level still active)
    wr(ra(2, b), 32'h0);
    rd(ra(2, b), r);
    chk("R6", "zero write keeps pending", r, one);
    wr(ra(2, b), one);
    rd(ra(2, b), r);
    chk(lvl ? "R3" : "R6", "clear while input active", r, lvl ? one : 32'h0);

    // opposite transition
    @(posedge clk); #1;
    pins[line] = idle_v;
    wait_cyc(4);
    rd(ra(2, b), r);
    chk(tag, "pending after opposite transition", r, (lvl || both) ? one : 32'h0);
    wr(ra(2, b), 32'hFF);
    rd(ra(2, b), r);
    chk(tag, "clear after input inactive", r, 32'h0);

    // restore quiet state
    wr(ra(0, b), 32'h3333_3333);
    pins = '0;
    wait_cyc(4);
    wr(ra(2, b), 32'hFF);
  endtask

  initial begin
    logic [31:0] r;
    wait_cyc(3);
    for (int b = 0; b < NB; b++) begin
      rd(ra(0, b), r); chk("R1", "reset config", r, 32'h0);
      rd(ra(1, b), r); chk("R1", "reset mask", r, 32'hFF);
      rd(ra(2, b), r); chk("R1", "reset pending", r, 32'h0);
    end
    chk("R1", "reset dedicated outputs", 32'(irq_line), 32'h0);
    chk("R1", "reset shared output", 32'(irq_shared), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset", {15'h0, irq_shared, irq_line}, 32'h0);

    for (int b = 0; b < NB; b++) wr(ra(0, b), 32'h3333_3333);
    wait_cyc(4);
    clear_all();

    wr(ra(0, 0), 32'hFFFF_FFFF);
    rd(ra(0, 0), r);
    chk("R2", "reserved bits read zero", r, 32'h7777_7777);
    wr(ra(0, 0), 32'h3333_3333);

    wr(ra(3, 0), 32'hFFFF_FFFF);
    rd(ra(3, 0), r); chk("R11", "unmapped read", r, 32'h0);
    rd(ra(1, 0), r); chk("R11", "unmapped write left mask", r, 32'hFF);
    rd(ra(0, 0), r); chk("R11", "unmapped write left config", r, 32'h3333_3333);

    wr(ra(1, 1), 32'hFFFF_FF00);
    rd(ra(1, 1), r); chk("R7", "mask upper bits dropped", r, 32'h0);
    wr(ra(1, 1), 32'hFF);

    wr(ra(0, 2), 32'h3333_3334);
    rd(ra(0, 2), r); chk("R11", "bank 2 config", r, 32'h3333_3334);
    rd(ra(0, 1), r); chk("R11", "bank 1 config untouched", r, 32'h3333_3333);
    wr(ra(0, 2), 32'h3333_3333);
    wait_cyc(4);
    clear_all();

    for (int line = 0; line < NL; line++) begin
      for (int code = 0; code < 8; code++) begin
        run_case(line, code);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule